// File: doc/BRIEF.md
# Quadrature Encoder Position Counter with Index

This block turns the two phase-shifted square waves of an incremental shaft encoder, plus its once-per-turn index pulse, into a position count. Each of the three inputs is first brought into the clock domain by a two-stage synchronizer. It then passes a noise filter that takes a new level only after the level has held for three clocks in a row. The decoder counts every edge of either phase, which gives four counts per encoder line. It takes the direction from which phase leads. The count wraps at a maximum value that software programs.

Software uses a small write port. Select 0 loads the maximum count. This also arms the counter, which until then holds at zero and ignores the encoder. Select 1 writes a control word whose bit 0 lets the index pulse clear the count. The block reports the position, the direction of the last step, the filtered input levels, an armed flag, a flag showing that an index edge has been seen since arming, and a one-cycle count-error pulse. The error pulse fires when an index edge arrives and the count is not zero.

Top module: `quad_pos_counter`

## Requirements
- R1: The levels on `levelA`, `levelB` and `levelZ` follow the encoder inputs after a two-flop synchronizer and a filter that takes a new level only once the synchronized input has differed from the held level for 3 consecutive clocks; a pulse of 2 clocks or less is ignored. All three reset to 0.
- R2: When exactly one of the filtered A and B levels changes, the position moves by one. With AB written as two bits, the order 00, 10, 11, 01, 00 counts up, and the reverse order counts down. `dirDown` shows the direction of the last step (1 = down). The position changes on the clock after the filtered level changes.
- R3: After reset, `initDone` is 0, the position is 0, and encoder steps and index edges have no effect. A write with `wrSel`=0 sets `initDone` to 1, loads the maximum count from `wrData` and clears the position.
- R4: An up step from the maximum count gives 0. A down step from 0 gives the maximum count.
- R5: A filtered sample in which A and B both change leaves the position unchanged.
- R6: A write with `wrSel`=1 stores `wrData` bit 0 as the index-clear enable (reset 0). When the enable is 1, a rising edge of the filtered index clears the position, and this takes priority over a step in the same clock. When the enable is 0, the index edge does not change the position.
- R7: `zeroSeen` goes to 1 on the first rising edge of the filtered index after arming. It is cleared by reset and by each write of the maximum count.
- R8: `countErr` pulses high for exactly one clock, one clock after an index rising edge that finds `zeroSeen` already at 1 and the position not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| encA | input | 1 | Encoder phase A, asynchronous |
| encB | input | 1 | Encoder phase B, asynchronous |
| encZ | input | 1 | Encoder index pulse, asynchronous |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 = maximum count, 1 = control (bit 0 index-clear enable) |
| wrData | input | CNT_W | Write data |
| position | output | CNT_W | Position count |
| dirDown | output | 1 | Direction of last step, 1 = down |
| levelA | output | 1 | Filtered A level |
| levelB | output | 1 | Filtered B level |
| levelZ | output | 1 | Filtered index level |
| initDone | output | 1 | Maximum count written, counter armed |
| zeroSeen | output | 1 | Index edge seen since arming |
| countErr | output | 1 | One-cycle count-error pulse |

## Verification
The assertions check on every cycle that the count stays at zero while unarmed, never exceeds the maximum, and holds still when the filtered levels and the write port are idle. They also check that an error pulse appears only with the index high after a first index has been seen, and that `zeroSeen` rises only with the index level. The bench scenarios show what a property cannot: the exact count after runs of steps in each direction, including wraps in both directions. They also show that short glitches and double changes are dropped, the difference between index-clear enabled and disabled, and the first-index versus later-index error rule. All of these are compared with a behavioural model on every clock.

// File: rtl/quad_pos_pkg.sv
package quad_pos_pkg;
  // strobes from decode control to the count datapath
  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic indexHit;
  } quadStrobes_t;
endpackage

// File: rtl/quad_in_filter.sv
module quad_in_filter #(
  parameter int STABLE_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level
);
  localparam int RUN_W = $clog2(STABLE_LEN + 1);

  logic syncQ1, syncQ2;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ1 <= 1'b0;
      syncQ2 <= 1'b0;
      runLen <= '0;
      level  <= 1'b0;
    end else begin
      syncQ1 <= rawIn;
      syncQ2 <= syncQ1;
      if (syncQ2 != level) begin
        if (runLen == RUN_W'(STABLE_LEN - 1)) begin
          level  <= syncQ2;
          runLen <= '0;
        end else begin
          runLen <= runLen + 1'b1;
        end
      end else begin
        runLen <= '0;
      end
    end
  end
endmodule

// File: rtl/quad_pos_ctrl.sv
module quad_pos_ctrl
  import quad_pos_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         levelA,
  input  logic         levelB,
  input  logic         levelZ,
  output quadStrobes_t strobes
);
  logic prevA, prevB, prevZ;
  logic changeA, changeB, oneChange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
      prevZ <= 1'b0;
    end else begin
      prevA <= levelA;
      prevB <= levelB;
      prevZ <= levelZ;
    end
  end

  always_comb begin
    changeA          = levelA ^ prevA;
    changeB          = levelB ^ prevB;
    oneChange        = changeA ^ changeB;
    // new A differing from old B marks the A-leads order
    strobes.stepUp   = oneChange & (levelA ^ prevB);
    strobes.stepDown = oneChange & ~(levelA ^ prevB);
    strobes.indexHit = levelZ & ~prevZ;
  end
endmodule

// File: rtl/quad_pos_datapath.sv
module quad_pos_datapath
  import quad_pos_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  quadStrobes_t     strobes,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] position,
  output logic [CNT_W-1:0] maxCount,
  output logic             dirDown,
  output logic             initDone,
  output logic             zeroSeen,
  output logic             countErr
);
  logic zeroEn;
  logic maxWrite;
  logic [CNT_W-1:0] upNext, downNext;

  always_comb begin
    maxWrite = wrEn & ~wrSel;
    upNext   = (position == maxCount) ? '0 : position + 1'b1;
    downNext = (position == '0) ? maxCount : position - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      zeroEn <= 1'b0;
    end else if (wrEn && wrSel) begin
      zeroEn <= wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      position <= '0;
      maxCount <= '0;
      dirDown  <= 1'b0;
      initDone <= 1'b0;
      zeroSeen <= 1'b0;
      countErr <= 1'b0;
    end else if (maxWrite) begin
      maxCount <= wrData;
      initDone <= 1'b1;
      position <= '0;
      zeroSeen <= 1'b0;
      countErr <= 1'b0;
    end else if (initDone) begin
      countErr <= strobes.indexHit & zeroSeen & (position != '0);
      if (strobes.indexHit) zeroSeen <= 1'b1;
      if (strobes.indexHit && zeroEn) begin
        position <= '0;
      end else if (strobes.stepUp) begin
        position <= upNext;
        dirDown  <= 1'b0;
      end else if (strobes.stepDown) begin
        position <= downNext;
        dirDown  <= 1'b1;
      end
    end else begin
      countErr <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import quad_pos_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int STABLE_LEN = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encA,
  input  logic             encB,
  input  logic             encZ,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] position,
  output logic             dirDown,
  output logic             levelA,
  output logic             levelB,
  output logic             levelZ,
  output logic             initDone,
  output logic             zeroSeen,
  output logic             countErr
);
  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] rawVec, levelVec;
  logic [CNT_W-1:0]  maxCountW;
  quadStrobes_t      strobes;

  assign rawVec = {encZ, encB, encA};

  for (genvar ch = 0; ch < NUM_IN; ch++) begin : g_filt
    quad_in_filter #(.STABLE_LEN(STABLE_LEN)) filt_i (
      .clk(clk), .rstN(rstN), .rawIn(rawVec[ch]), .level(levelVec[ch])
    );
  end

  assign levelA = levelVec[0];
  assign levelB = levelVec[1];
  assign levelZ = levelVec[2];

  quad_pos_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .levelA(levelA), .levelB(levelB),
    .levelZ(levelZ), .strobes(strobes)
  );

  quad_pos_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .position(position), .maxCount(maxCountW),
    .dirDown(dirDown), .initDone(initDone), .zeroSeen(zeroSeen),
    .countErr(countErr)
  );
endmodule

// File: rtl/quad_pos_chk.sv
module quad_pos_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [CNT_W-1:0] position,
  input logic [CNT_W-1:0] maxCount,
  input logic             levelA,
  input logic             levelB,
  input logic             levelZ,
  input logic             initDone,
  input logic             zeroSeen,
  input logic             countErr
);
  assert_idle_until_armed_R3: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> position == '0);

  assert_within_max_R4: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> position <= maxCount);

  assert_hold_when_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (levelA == $past(levelA) && levelB == $past(levelB) &&
     levelZ == $past(levelZ) && !wrEn) |=> $stable(position));

  assert_err_needs_index_R8: assert property (@(posedge clk) disable iff (!rstN)
    countErr |-> (levelZ && zeroSeen));

  assert_seen_with_index_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(zeroSeen) |-> levelZ);
endmodule

bind quad_pos_counter quad_pos_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .position(position),
  .maxCount(maxCountW), .levelA(levelA), .levelB(levelB), .levelZ(levelZ),
  .initDone(initDone), .zeroSeen(zeroSeen), .countErr(countErr)
);

// File: tb/quad_pos_counter_tb.sv
`timescale 1ns/1ps
module quad_pos_counter_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic encA = 1'b0, encB = 1'b0, encZ = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0;
  logic [CNT_W-1:0] wrData = '0;
  logic [CNT_W-1:0] position;
  logic dirDown, levelA, levelB, levelZ, initDone, zeroSeen, countErr;

  int checks = 0;
  int fails = 0;
  int errPulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  quad_pos_counter #(.CNT_W(CNT_W)) dut_i (.*);

  // ---------------- behavioural reference ----------------
  int  mS1[3], mS2[3], mRun[3];
  int  mLvl[3], mPrv[3];
  int  mPos, mMax;
  bit  mInit, mSeen, mErr, mDir, mZen;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin
        mS1[i] = 0; mS2[i] = 0; mRun[i] = 0; mLvl[i] = 0; mPrv[i] = 0;
      end
      mPos = 0; mMax = 0; mInit = 0; mSeen = 0; mErr = 0; mDir = 0; mZen = 0;
    end else begin
      bit zr, ca, cb, up;
      bit oldZen;
      oldZen = mZen;
      zr = (mLvl[2] == 1) && (mPrv[2] == 0);
      ca = mLvl[0] != mPrv[0];
      cb = mLvl[1] != mPrv[1];
      up = (mLvl[0] != mPrv[1]);
      if (wrEn && !wrSel) begin
        mMax = int'(wrData); mInit = 1; mPos = 0; mSeen = 0; mErr = 0;
      end else if (mInit) begin
        mErr = zr && mSeen && (mPos != 0);
        if (zr) mSeen = 1;
        if (zr && oldZen) mPos = 0;
        else if (ca != cb) begin
          if (up) begin mPos = (mPos == mMax) ? 0 : mPos + 1; mDir = 0; end
          else    begin mPos = (mPos == 0) ? mMax : mPos - 1; mDir = 1; end
        end
      end else mErr = 0;
      if (wrEn && wrSel) mZen = wrData[0];
      for (int i = 0; i < 3; i++) begin
        mPrv[i] = mLvl[i];
        if (mS2[i] != mLvl[i]) begin
          if (mRun[i] == 2) begin mLvl[i] = mS2[i]; mRun[i] = 0; end
          else mRun[i]++;
        end else mRun[i] = 0;
        mS2[i] = mS1[i];
      end
      mS1[0] = encA; mS1[1] = encB; mS1[2] = encZ;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(int'(position) == mPos, "R2/R4 model position", int'(position), mPos);
      check(dirDown == mDir, "R2 model dirDown", dirDown, mDir);
      check({levelZ, levelB, levelA} == {mLvl[2][0], mLvl[1][0], mLvl[0][0]},
            "R1 model levels", {levelZ, levelB, levelA},
            {mLvl[2][0], mLvl[1][0], mLvl[0][0]});
      check(initDone == mInit, "R3 model initDone", initDone, mInit);
      check(zeroSeen == mSeen, "R7 model zeroSeen", zeroSeen, mSeen);
      check(countErr == mErr, "R8 model countErr", countErr, mErr);
      if (countErr) errPulses++;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input bit sel, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = CNT_W'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // one quadrature step; A toggles when A==B for up
  task automatic step(input bit goUp);
    @(negedge clk);
    if ((encA == encB) == goUp) encA = ~encA;
    else encB = ~encB;
    idle(8);
  endtask

  task automatic indexPulse();
    @(negedge clk); encZ = 1'b1;
    idle(8);
    encZ = 1'b0;
    idle(8);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    check(position == '0 && !initDone && !zeroSeen && !countErr,
          "R3 reset state", position, 0);

    // R3: steps before arming do nothing
    repeat (3) step(1);
    check(position == '0, "R3 no count before arming", position, 0);
    check(levelA == encA && levelB == encB, "R1 levels follow inputs",
          {levelA, levelB}, {encA, encB});

    regWrite(0, 9);
    idle(1);
    check(initDone && position == '0, "R3 armed after max write", position, 0);

    // R2/R4: 12 up steps with max 9 -> 2
    repeat (12) step(1);
    check(position == 2 && !dirDown, "R4 up wrap", position, 2);

    // R2/R4: 5 down steps -> 7
    repeat (5) step(0);
    check(position == 7 && dirDown, "R4 down wrap", position, 7);

    // R5: both phases change together
    @(negedge clk); encA = ~encA; encB = ~encB; idle(10);
    check(position == 7, "R5 double change ignored", position, 7);

    // R1: 2-clock glitch on A
    @(negedge clk); encA = ~encA; idle(2); encA = ~encA; idle(10);
    check(position == 7, "R1 short glitch ignored", position, 7);

    // R6 disabled / R7 first index, no error
    indexPulse();
    check(position == 7, "R6 index without clear", position, 7);
    check(zeroSeen, "R7 first index seen", zeroSeen, 1);
    check(errPulses == 0, "R8 no error on first index", errPulses, 0);

    // R8: second index at non-zero count
    indexPulse();
    check(errPulses == 1, "R8 error at non-zero count", errPulses, 1);

    // R6 enabled: index clears; next index at zero has no error
    regWrite(1, 1);
    indexPulse();
    check(position == 0, "R6 index clears position", position, 0);
    check(errPulses == 2, "R8 error counted before clear", errPulses, 2);
    indexPulse();
    check(errPulses == 2, "R8 no error at zero", errPulses, 2);

    step(0);
    check(position == 9 && dirDown, "R4 down from zero", position, 9);

    // R7: rearm clears zeroSeen
    regWrite(0, 4);
    idle(1);
    check(!zeroSeen && position == 0, "R7 rearm clears seen", zeroSeen, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule